// File: doc/BRIEF.md
# Echo Canceller Mode Latch and Start Sequencer

This block sits between the static configuration pins of a speech echo canceller and its per-sample processing core. It samples six mode inputs (center clipping, pass-through, coefficient freeze, attenuator enable, gain control and howling-detector enable) only at two moments: the first clock after reset is released, and the clock at which a high-to-low transition of the processing interrupt is accepted. The sampled value is held unchanged until the next such moment, so the core sees one consistent configuration for a whole 8 kHz sample period.

The block also runs the reset and power-down sequence. After reset it blanks the interrupt for a fixed initialisation window counted in system clocks. Power-down disables the pin drivers and the generated sync/clock outputs, ignores every input, and is left only through a fresh reset. A slave device in a chained configuration forces all mode bits except pass-through to their low values. Each accepted interrupt edge produces a one-cycle start strobe, and a completion signal from the core is turned into a one-cycle end-of-cycle pulse.

Top module: `ecm_mode_seq`

## Requirements
- R1: On the first rising clock edge after reset is released (with power-down inactive), `mode_o` takes the value of `mode_pins` (with the R8 forcing applied). Bit encoding for both: bit0 center clip, bit1 pass-through, bit2 coefficient freeze, bit3 attenuator enable (active low), bit4 gain control (active high), bit5 howling detector enable (active low).
- R2: While running, an interrupt falling edge (`int_n` sampled 1 then 0 on consecutive clock edges) latches `mode_pins` into `mode_o` and raises `proc_start` for exactly one cycle, both visible after the edge that sampled 0; `int_n` held low produces no further strobe.
- R3: `mode_o` changes only at the events of R1 and R2; pin changes between them have no effect.
- R4: An interrupt falling edge sampled before the (BLANK_CYCLES+3)-th clock edge after reset release is ignored; from that edge on, edges are accepted.
- R5: While reset is asserted: `pins_oe`=0, `flags_force`=1, `eoc`=0, `proc_start`=0 and `genclk_en`=1.
- R6: One cycle after `pdn_n` is sampled 0: `pins_oe`=0, `genclk_en`=0, `flags_force`=1; while power-down lasts, interrupt edges and pin changes are ignored and `mode_o` holds.
- R7: After `pdn_n` returns to 1 without a reset, `pins_oe` stays 0, `genclk_en` returns to 1, and no interrupt edge or core completion is acted on until the next reset.
- R8: When `is_slave`=1 at a latch event, bits 0, 2, 3, 4 and 5 of `mode_o` are stored as 0 and bit1 follows `mode_pins[1]`.
- R9: `eoc` pulses for one cycle after `core_done` is sampled 1 while running, and stays 0 otherwise.
- R10: `pins_oe`=1 during the initialisation window and while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down request |
| int_n | input | 1 | Processing interrupt, falling edge starts a sample cycle |
| is_slave | input | 1 | 1 selects slave behaviour of the mode bits |
| mode_pins | input | 6 | Raw mode inputs, encoding per R1 |
| core_done | input | 1 | Core reports end of per-sample processing |
| mode_o | output | 6 | Latched mode bits, encoding per R1 |
| proc_start | output | 1 | One-cycle start strobe per accepted interrupt edge |
| eoc | output | 1 | One-cycle end-of-cycle pulse |
| pins_oe | output | 1 | Drive enable for serial outputs and parallel bus |
| flags_force | output | 1 | Forces transfer flag outputs high |
| genclk_en | output | 1 | 0 forces generated sync and clock outputs low |

## Verification
The hardest state to reach from the ports is the one after power-down ends without a reset, where the block looks alive (generated clocks run again) yet must refuse interrupt edges and completions. The bench reaches it by first converging into normal running through a shortened blanking window, walking a vector table of interrupt edges, pin changes and slave selections, then dropping and raising `pdn_n` and firing an interrupt edge together with `core_done` before any reset. The blanking boundary is exercised by an interrupt edge placed inside the window right after reset release.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

    localparam int MODE_W = 6;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_INIT    = 3'd1,
        ST_RUN     = 3'd2,
        ST_PDOWN   = 3'd3,
        ST_WAITRST = 3'd4
    } seq_state_e;

    // Field order gives bit0 = cclip ... bit5 = howl_n
    typedef struct packed {
        logic howl_n;
        logic gain;
        logic att_n;
        logic freeze;
        logic thru;
        logic cclip;
    } mode_t;

    localparam mode_t MODE_RST = '{howl_n: 1'b1, gain: 1'b0, att_n: 1'b1,
                                   freeze: 1'b0, thru: 1'b0, cclip: 1'b0};

    function automatic mode_t slave_force(input mode_t m);
        mode_t r;
        r      = '0;
        r.thru = m.thru;
        return r;
    endfunction

endpackage

// File: rtl/ecm_fall_det.sv
module ecm_fall_det #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fall_o
);

    typedef struct packed {
        logic prev;
    } fd_state_t;

    fd_state_t fd_d, fd_q;

    always_comb begin
        fd_d      = fd_q;
        fd_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fd_q.prev <= IDLE_LEVEL;
        end else begin
            fd_q <= fd_d;
        end
    end

    assign fall_o = fd_q.prev & ~sig_i;

endmodule

// File: rtl/ecm_blank_timer.sv
module ecm_blank_timer #(
    parameter int unsigned CYCLES = 1920000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_en_i,
    output logic expired_o
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } bt_state_t;

    bt_state_t bt_d, bt_q;

    assign expired_o = (bt_q.cnt == LIMIT);

    always_comb begin
        bt_d = bt_q;
        if (clear_i) begin
            bt_d.cnt = '0;
        end else if (count_en_i && !expired_o) begin
            bt_d.cnt = bt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q.cnt <= '0;
        end else begin
            bt_q <= bt_d;
        end
    end

endmodule

// File: rtl/ecm_mode_reg.sv
module ecm_mode_reg
    import ecm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              slave_i,
    input  logic [MODE_W-1:0] pins_i,
    output mode_t             mode_o
);

    typedef struct packed {
        mode_t mode;
    } mr_state_t;

    mr_state_t mr_d, mr_q;
    mode_t     pins_m;

    assign pins_m = mode_t'(pins_i);

    always_comb begin
        mr_d = mr_q;
        if (load_i) begin
            mr_d.mode = slave_i ? slave_force(pins_m) : pins_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_q.mode <= MODE_RST;
        end else begin
            mr_q <= mr_d;
        end
    end

    assign mode_o = mr_q.mode;

endmodule

// File: rtl/ecm_mode_seq.sv
module ecm_mode_seq
    import ecm_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 1920000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic              int_n,
    input  logic              is_slave,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              core_done,
    output logic [MODE_W-1:0] mode_o,
    output logic              proc_start,
    output logic              eoc,
    output logic              pins_oe,
    output logic              flags_force,
    output logic              genclk_en
);

    typedef struct packed {
        seq_state_e state;
        logic       start;
        logic       eoc;
    } sq_state_t;

    sq_state_t  sq_d, sq_q;
    seq_state_e state_q;
    logic       int_fall;
    logic       blank_done;
    logic       latch_now;
    logic       blank_clr;
    mode_t      mode_cur;

    ecm_fall_det #(.IDLE_LEVEL(1'b1)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (int_n),
        .fall_o (int_fall)
    );

    ecm_blank_timer #(.CYCLES(BLANK_CYCLES)) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (blank_clr),
        .count_en_i (sq_q.state == ST_INIT),
        .expired_o  (blank_done)
    );

    ecm_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (latch_now),
        .slave_i (is_slave),
        .pins_i  (mode_pins),
        .mode_o  (mode_cur)
    );

    always_comb begin
        sq_d       = sq_q;
        sq_d.start = 1'b0;
        sq_d.eoc   = 1'b0;
        latch_now  = 1'b0;
        blank_clr  = 1'b0;
        case (sq_q.state)
            ST_RESET: begin
                if (!pdn_n) begin
                    sq_d.state = ST_PDOWN;
                end else begin
                    latch_now  = 1'b1;
                    blank_clr  = 1'b1;
                    sq_d.state = ST_INIT;
                end
            end
            ST_INIT: begin
                if (!pdn_n) begin
                    sq_d.state = ST_PDOWN;
                end else if (blank_done) begin
                    sq_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!pdn_n) begin
                    sq_d.state = ST_PDOWN;
                end else begin
                    if (int_fall) begin
                        latch_now  = 1'b1;
                        sq_d.start = 1'b1;
                    end
                    sq_d.eoc = core_done;
                end
            end
            ST_PDOWN: begin
                if (pdn_n) begin
                    sq_d.state = ST_WAITRST;
                end
            end
            ST_WAITRST: begin
                if (!pdn_n) begin
                    sq_d.state = ST_PDOWN;
                end
            end
            default: begin
                sq_d.state = ST_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q.state <= ST_RESET;
            sq_q.start <= 1'b0;
            sq_q.eoc   <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign state_q     = sq_q.state;
    assign mode_o      = mode_cur;
    assign proc_start  = sq_q.start;
    assign eoc         = sq_q.eoc;
    assign pins_oe     = (sq_q.state == ST_INIT) || (sq_q.state == ST_RUN);
    assign flags_force = (sq_q.state == ST_RESET) || (sq_q.state == ST_PDOWN)
                      || (sq_q.state == ST_WAITRST);
    assign genclk_en   = (sq_q.state != ST_PDOWN);

endmodule

// File: rtl/ecm_mode_seq_chk.sv
module ecm_mode_seq_chk
    import ecm_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 1920000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pdn_n,
    input logic              int_n,
    input logic              is_slave,
    input logic              core_done,
    input logic [MODE_W-1:0] mode_o,
    input logic              proc_start,
    input logic              eoc,
    input logic              pins_oe,
    input logic              flags_force,
    input logic              genclk_en,
    input seq_state_e        state_i
);

    localparam int unsigned SAT = BLANK_CYCLES + 3;
    localparam int SW = $clog2(SAT + 1);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != SW'(SAT)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r2_start_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        proc_start |-> (!$past(int_n) && $past(int_n, 2)));

    a_r3_mode_only_at_events: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> (proc_start || $past(state_i) == ST_RESET));

    a_r4_blank_window: assert property (@(posedge clk) disable iff (!rst_n)
        proc_start |-> (since_q >= SW'(SAT)));

    a_r5_reset_outputs: assert property (@(posedge clk)
        !rst_n |-> (!pins_oe && flags_force && !eoc && !proc_start && genclk_en));

    a_r6_pdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (!pins_oe && !genclk_en && flags_force && !proc_start));

    a_r7_wait_for_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WAITRST && pdn_n) |=> (state_i == ST_WAITRST && !pins_oe));

    a_r8_slave_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start && $past(is_slave)) |-> (mode_o[0] == 1'b0 && mode_o[5:2] == 4'b0000));

    a_r9_eoc_source: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> $past(core_done));

endmodule

bind ecm_mode_seq ecm_mode_seq_chk #(.BLANK_CYCLES(BLANK_CYCLES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdn_n       (pdn_n),
    .int_n       (int_n),
    .is_slave    (is_slave),
    .core_done   (core_done),
    .mode_o      (mode_o),
    .proc_start  (proc_start),
    .eoc         (eoc),
    .pins_oe     (pins_oe),
    .flags_force (flags_force),
    .genclk_en   (genclk_en),
    .state_i     (state_q)
);

// File: tb/ecm_mode_seq_tb_top.sv
module ecm_mode_seq_tb_top;

    localparam int unsigned BLANK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       pdn_n = 1'b1;
    logic       int_n = 1'b1;
    logic       is_slave = 1'b0;
    logic [5:0] mode_pins = 6'h00;
    logic       core_done = 1'b0;
    logic [5:0] mode_o;
    logic       proc_start, eoc, pins_oe, flags_force, genclk_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ecm_mode_seq #(.BLANK_CYCLES(BLANK)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pdn_n       (pdn_n),
        .int_n       (int_n),
        .is_slave    (is_slave),
        .mode_pins   (mode_pins),
        .core_done   (core_done),
        .mode_o      (mode_o),
        .proc_start  (proc_start),
        .eoc         (eoc),
        .pins_oe     (pins_oe),
        .flags_force (flags_force),
        .genclk_en   (genclk_en)
    );

    typedef struct packed {
        logic       in_int_n;
        logic [5:0] in_pins;
        logic       in_slave;
        logic       in_done;
        logic       x_start;
        logic [5:0] x_mode;
        logic       x_eoc;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{1'b1, 6'h15, 1'b0, 1'b0, 1'b0, 6'h2A, 1'b0},  // R3 pin change ignored
        '{1'b0, 6'h15, 1'b0, 1'b0, 1'b1, 6'h15, 1'b0},  // R2 fall latches
        '{1'b0, 6'h3F, 1'b0, 1'b0, 1'b0, 6'h15, 1'b0},  // R2 held low, no strobe
        '{1'b1, 6'h3F, 1'b0, 1'b1, 1'b0, 6'h15, 1'b1},  // R9 completion pulse
        '{1'b1, 6'h00, 1'b0, 1'b0, 1'b0, 6'h15, 1'b0},  // R9 pulse ends
        '{1'b0, 6'h3F, 1'b1, 1'b0, 1'b1, 6'h02, 1'b0},  // R8 slave keeps thru only
        '{1'b1, 6'h3D, 1'b1, 1'b0, 1'b0, 6'h02, 1'b0},  // R3 hold
        '{1'b0, 6'h3D, 1'b1, 1'b0, 1'b1, 6'h00, 1'b0},  // R8 thru follows pin
        '{1'b1, 6'h0C, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0},  // R3 hold
        '{1'b0, 6'h0C, 1'b0, 1'b0, 1'b1, 6'h0C, 1'b0},  // R2 master latch
        '{1'b1, 6'h0C, 1'b0, 1'b1, 1'b0, 6'h0C, 1'b1},  // R9
        '{1'b0, 6'h0C, 1'b0, 1'b1, 1'b1, 6'h0C, 1'b1}   // R2 and R9 together
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        tick(); tick(); tick();
        // R5 outputs held in reset
        check("R5 pins_oe", pins_oe, 0);
        check("R5 flags_force", flags_force, 1);
        check("R5 eoc", eoc, 0);
        check("R5 proc_start", proc_start, 0);
        check("R5 genclk_en", genclk_en, 1);

        mode_pins = 6'h2A;
        rst_n = 1'b1;
        tick();                                // first edge after release
        check("R1 mode latched at release", mode_o, 6'h2A);
        check("R10 pins_oe during init", pins_oe, 1);
        check("R10 flags released", flags_force, 0);

        mode_pins = 6'h11;
        repeat (4) tick();
        int_n = 1'b0;                          // fall sampled at edge 6
        tick();
        check("R4 blanked start", proc_start, 0);
        check("R4 blanked mode", mode_o, 6'h2A);
        int_n = 1'b1;
        repeat (20) tick();
        check("R10 pins_oe while running", pins_oe, 1);

        foreach (VECS[i]) begin
            int_n     = VECS[i].in_int_n;
            mode_pins = VECS[i].in_pins;
            is_slave  = VECS[i].in_slave;
            core_done = VECS[i].in_done;
            tick();
            check($sformatf("R2 start vec%0d", i), proc_start, VECS[i].x_start);
            check($sformatf("R3 mode vec%0d", i), mode_o, VECS[i].x_mode);
            check($sformatf("R9 eoc vec%0d", i), eoc, VECS[i].x_eoc);
        end

        // R6 power-down
        core_done = 1'b0;
        pdn_n = 1'b0; int_n = 1'b1; mode_pins = 6'h3F;
        tick();
        check("R6 pins_oe", pins_oe, 0);
        check("R6 genclk_en", genclk_en, 0);
        check("R6 flags_force", flags_force, 1);
        int_n = 1'b0;
        tick();
        check("R6 start ignored", proc_start, 0);
        check("R6 mode held", mode_o, 6'h0C);

        // R7 power-down released without reset
        pdn_n = 1'b1; int_n = 1'b1;
        tick();
        check("R7 pins_oe stays low", pins_oe, 0);
        check("R7 genclk_en back", genclk_en, 1);
        int_n = 1'b0; core_done = 1'b1;
        tick();
        check("R7 start refused", proc_start, 0);
        check("R9 eoc not running", eoc, 0);
        check("R7 mode held", mode_o, 6'h0C);

        // fresh reset
        core_done = 1'b0; int_n = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R5 pins_oe on reset", pins_oe, 0);
        check("R5 flags on reset", flags_force, 1);
        check("R5 genclk on reset", genclk_en, 1);
        tick();
        mode_pins = 6'h33;
        rst_n = 1'b1;
        tick();
        check("R1 mode relatched", mode_o, 6'h33);
        check("R10 pins_oe after reset", pins_oe, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule